// File: doc/BRIEF.md
# Resource Selector with Timestamp Trigger

This block turns a set of internal status signals into a small vector of resource bits and fires a timestamp request from that vector. Each programmable selector holds a control word naming one status group and a bitmask of members inside that group. Its output is the OR of the chosen members, optionally inverted, and is registered once. Entry 0 of the vector is a constant false and entry 1 a constant true. The programmable selectors fill entries 2 and up, and there are twice as many entries as implemented pairs.

A timestamp control register holds an 8-bit event selector over the vector. The selector can name one entry, or a pair of entries whose combined result can be inverted. On every cycle that the selected event is true, the block raises a one-cycle timestamp request. A typical set-up for a periodic timestamp picks group 2 and the mask bit of a free counter in one selector, then points the event selector at that selector. The counters, sequencer, timestamp value and packet formatting all live outside the block.

Control words and the timestamp control are written through a simple write port with an enable, an address and a data word.

Top module: `rsel_ts_top`

## Requirements
- R1: After reset, `res_vec` reads 0b10 in its two low bits and 0 in every programmable entry, and `ts_req` is 0.
- R2: `res_vec[0]` is always 0 and `res_vec[1]` is always 1. Writes to addresses 0 and 1 change nothing.
- R3: A selector control word has the mask in bits 15:0, the group code in bits 19:16, INV in bit 20 and PAIRINV in bit 21. A programmable entry equals the OR of (members AND mask), XOR INV, taken from the inputs and control of the previous clock edge.
- R4: Group code 2 maps mask bit n (n < NUM_CNT) to `cnt_zero[n]` and mask bits 12..15 to `seq_state[0..3]`. Several mask bits set at once OR their members.
- R5: Group code 0 selects `ext_in[15:0]` and group code 1 selects `cmp_in[15:0]`. Any other group code has no members, so the entry is 0, or 1 when INV is set.
- R6: INV inverts a single entry. PAIRINV has no effect on the entry itself, so with INV clear the entry is not inverted.
- R7: The timestamp control sits at address 2^(ADDR_W-1), which is 32 by default. When data bit 7 is 0, data bits 4:0 name a single entry. An index at or above NUM_SEL is always false.
- R8: When data bit 7 is 1, data bits 3:0 name pair p. The event is (entry 2p OR entry 2p+1) XOR the PAIRINV bit last written to selector 2p, and PAIRINV written to odd selectors is ignored. Pair 0 and any p at or above NUM_PAIRS are always false.
- R9: `ts_req` is 1 for exactly the cycles after those edges at which the selected event, evaluated on `res_vec`, was true. It is a per-cycle pulse, so a continuously true event keeps it high.
- R10: A write takes effect at the edge that samples it. The next edge uses the new control. Writes to addresses from NUM_SEL up to the timestamp address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Selector index, or the timestamp control address |
| wr_data | input | 22 | Control word or timestamp event selector |
| ext_in | input | 16 | Group 0 status members |
| cmp_in | input | 16 | Group 1 status members |
| cnt_zero | input | NUM_CNT | Counter-at-zero flags (group 2, low members) |
| seq_state | input | NUM_SEQ | Sequencer state flags (group 2, members 12 and up) |
| res_vec | output | 2*NUM_PAIRS | Resource vector |
| ts_req | output | 1 | Timestamp request pulse |

## Verification
Two things can land on the same clock edge: a control write that retargets a selector or the event selector, and a status change or true event under the old setting. The bench writes a selector's control word in the same cycle that the status members it selects change. It also rewrites the timestamp control while the old event is true, and it mixes random writes with random status over a long run. A behavioural reference model updates on every edge and is compared every cycle. From it the bench expects the old control to govern the edge of the write and the new control to govern the edge after it.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
    localparam int MEMB_W    = 16;  // members per status group
    localparam int CFG_W     = 21;  // stored selector fields: inv, group, mask
    localparam int WORD_W    = 22;  // control word including the pair-invert bit
    localparam int CNT_SLOTS = 12;  // group 2 members reserved for counters
    localparam int SEQ_SLOTS = 4;   // group 2 members reserved for sequencer states

    localparam logic [3:0] GRP_EXT    = 4'd0;
    localparam logic [3:0] GRP_CMP    = 4'd1;
    localparam logic [3:0] GRP_CNTSEQ = 4'd2;

    typedef struct packed {
        logic              inv;
        logic [3:0]        grp;
        logic [MEMB_W-1:0] mask;
    } sel_cfg_t;

    typedef struct packed {
        logic       is_pair;
        logic [4:0] idx;
    } evsel_t;
endpackage

// File: rtl/rsel_regs.sv
module rsel_regs
    import rsel_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int ADDR_W    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    output sel_cfg_t [2*NUM_PAIRS-1:2] cfg_o,
    output logic [NUM_PAIRS-1:1]     pinv_o,
    output evsel_t                   ts_o
);
    localparam int NUM_SEL = 2 * NUM_PAIRS;
    localparam logic [ADDR_W-1:0] TS_ADDR = ADDR_W'(2 ** (ADDR_W - 1));

    typedef struct packed {
        sel_cfg_t [NUM_SEL-1:2] cfg;
        logic [NUM_PAIRS-1:1]   pinv;
        evsel_t                 ts;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == TS_ADDR) begin
                st_d.ts.is_pair = wr_data[7];
                st_d.ts.idx     = wr_data[4:0];
            end
            for (int i = 2; i < NUM_SEL; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    st_d.cfg[i] = sel_cfg_t'(wr_data[CFG_W-1:0]);
                    if ((i % 2) == 0) begin
                        st_d.pinv[i/2] = wr_data[WORD_W-1];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign pinv_o = st_q.pinv;
    assign ts_o   = st_q.ts;

    // R7
    ts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == TS_ADDR) |=>
            (ts_o.idx == $past(wr_data[4:0]) && ts_o.is_pair == $past(wr_data[7])));

    // R10
    ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NUM_SEL) && wr_addr != TS_ADDR) |=> $stable(st_q));

    // R2
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < ADDR_W'(2)) |=> $stable(st_q));
endmodule

// File: rtl/rsel_unit.sv
module rsel_unit
    import rsel_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int NUM_SEQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sel_cfg_t           cfg,
    input  logic [MEMB_W-1:0]  ext_in,
    input  logic [MEMB_W-1:0]  cmp_in,
    input  logic [NUM_CNT-1:0] cnt_zero,
    input  logic [NUM_SEQ-1:0] seq_state,
    output logic               hit_o
);
    logic [MEMB_W-1:0] members;
    logic              hit_d, hit_q;

    always_comb begin
        case (cfg.grp)
            GRP_EXT:    members = ext_in;
            GRP_CMP:    members = cmp_in;
            GRP_CNTSEQ: members = {SEQ_SLOTS'(seq_state), CNT_SLOTS'(cnt_zero)};
            default:    members = '0;
        endcase
        hit_d = (|(members & cfg.mask)) ^ cfg.inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit_d;
        end
    end

    assign hit_o = hit_q;

    // R3
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mask == '0 && !cfg.inv) |=> !hit_o);

    // R6
    inv_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mask == '0 && cfg.inv) |=> hit_o);

    // R5
    bad_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.grp > GRP_CNTSEQ) |=> (hit_o == $past(cfg.inv)));
endmodule

// File: rtl/rsel_event.sv
module rsel_event
    import rsel_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_PAIRS-1:0] res,
    input  logic [NUM_PAIRS-1:1]   pinv,
    input  evsel_t                 ts_sel,
    output logic                   ts_req
);
    localparam int NUM_SEL = 2 * NUM_PAIRS;

    logic ev_d, ev_q;

    always_comb begin
        ev_d = 1'b0;
        if (ts_sel.is_pair) begin
            for (int p = 1; p < NUM_PAIRS; p++) begin
                if (ts_sel.idx[3:0] == 4'(p)) begin
                    ev_d = (res[2*p] | res[2*p+1]) ^ pinv[p];
                end
            end
        end else begin
            for (int i = 0; i < NUM_SEL; i++) begin
                if (ts_sel.idx == 5'(i)) begin
                    ev_d = res[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= 1'b0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign ts_req = ev_q;

    // R9
    always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_sel.is_pair && ts_sel.idx == 5'd1) |=> ts_req);

    // R7
    always_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_sel.is_pair && ts_sel.idx == 5'd0) |=> !ts_req);

    // R8
    pair_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_sel.is_pair && ts_sel.idx[3:0] == 4'd0) |=> !ts_req);
endmodule

// File: rtl/rsel_ts_top.sv
module rsel_ts_top
    import rsel_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int NUM_CNT   = 4,
    parameter int NUM_SEQ   = 4,
    parameter int ADDR_W    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic [MEMB_W-1:0]      ext_in,
    input  logic [MEMB_W-1:0]      cmp_in,
    input  logic [NUM_CNT-1:0]     cnt_zero,
    input  logic [NUM_SEQ-1:0]     seq_state,
    output logic [2*NUM_PAIRS-1:0] res_vec,
    output logic                   ts_req
);
    localparam int NUM_SEL = 2 * NUM_PAIRS;

    sel_cfg_t [NUM_SEL-1:2] cfg;
    logic [NUM_PAIRS-1:1]   pinv;
    evsel_t                 ts_sel;
    logic [NUM_SEL-1:0]     res;

    rsel_regs #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cfg_o  (cfg),
        .pinv_o (pinv),
        .ts_o   (ts_sel)
    );

    assign res[0] = 1'b0;
    assign res[1] = 1'b1;

    for (genvar g = 2; g < NUM_SEL; g++) begin : g_sel
        rsel_unit #(.NUM_CNT(NUM_CNT), .NUM_SEQ(NUM_SEQ)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (cfg[g]),
            .ext_in   (ext_in),
            .cmp_in   (cmp_in),
            .cnt_zero (cnt_zero),
            .seq_state(seq_state),
            .hit_o    (res[g])
        );
    end

    rsel_event #(.NUM_PAIRS(NUM_PAIRS)) u_event (
        .clk   (clk),
        .rst_n (rst_n),
        .res   (res),
        .pinv  (pinv),
        .ts_sel(ts_sel),
        .ts_req(ts_req)
    );

    assign res_vec = res;

    // R4
    cnt_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[2].grp == GRP_CNTSEQ && !cfg[2].inv && cfg[2].mask[0] && cnt_zero[0]) |=> res_vec[2]);
endmodule

// File: tb/tb_rsel_ts_top.sv
`timescale 1ns/1ps
module tb_rsel_ts_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic [15:0] ext_in = '0;
    logic [15:0] cmp_in = '0;
    logic [3:0]  cnt_zero = '0;
    logic [3:0]  seq_state = '0;
    logic [7:0]  res_vec;
    logic        ts_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    rsel_ts_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_in(ext_in), .cmp_in(cmp_in), .cnt_zero(cnt_zero), .seq_state(seq_state),
        .res_vec(res_vec), .ts_req(ts_req)
    );

    // behavioural reference model
    logic [21:0] ctrl_m [0:7];
    logic [7:0]  ts_m  = 8'h00;
    logic [7:0]  res_m = 8'h02;
    logic        req_m = 1'b0;

    function automatic logic sel_eval(logic [21:0] w, logic [15:0] e, logic [15:0] c,
                                      logic [3:0] cn, logic [3:0] sq);
        int  g = int'(w[19:16]);
        logic hit = 1'b0;
        for (int n = 0; n < 16; n++) begin
            if (w[n]) begin
                logic v;
                if (g == 0) v = e[n];
                else if (g == 1) v = c[n];
                else if (g == 2) v = (n < 4) ? cn[n] : ((n >= 12) ? sq[n-12] : 1'b0);
                else v = 1'b0;
                hit = hit | v;
            end
        end
        return hit ^ w[20];
    endfunction

    function automatic logic ev_eval(logic [7:0] s, logic [7:0] r, logic [21:0] c2,
                                     logic [21:0] c4, logic [21:0] c6);
        if (s[7]) begin
            int p = int'(s[3:0]);
            logic pv;
            if (p == 1) pv = c2[21];
            else if (p == 2) pv = c4[21];
            else if (p == 3) pv = c6[21];
            else return 1'b0;
            return (r[2*p] | r[2*p+1]) ^ pv;
        end else begin
            int i = int'(s[4:0]);
            return (i < 8) ? r[i] : 1'b0;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) ctrl_m[i] = '0;
            ts_m  = 8'h00;
            res_m = 8'h02;
            req_m = 1'b0;
        end else begin
            logic [7:0] nres;
            req_m = ev_eval(ts_m, res_m, ctrl_m[2], ctrl_m[4], ctrl_m[6]);
            nres  = 8'h02;
            for (int i = 2; i < 8; i++)
                nres[i] = sel_eval(ctrl_m[i], ext_in, cmp_in, cnt_zero, seq_state);
            if (wr_en) begin
                if (wr_addr == 6'd32) ts_m = wr_data[7:0];
                else if (wr_addr >= 6'd2 && wr_addr < 6'd8) ctrl_m[wr_addr] = wr_data;
            end
            res_m = nres;
        end
    end

    task automatic check(string tag);
        n_tests++;
        if (res_vec !== res_m || ts_req !== req_m) begin
            n_fail++;
            $display("FAIL %s: res_vec=%b ts_req=%b expected res_vec=%b ts_req=%b",
                     tag, res_vec, ts_req, res_m, req_m);
        end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(logic [5:0] a, logic [21:0] d, string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    function automatic logic [21:0] cw(bit pinv, bit inv, logic [3:0] grp, logic [15:0] mask);
        return {pinv, inv, grp, mask};
    endfunction

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset");
        if (res_vec !== 8'h02 || ts_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: res_vec=%b ts_req=%b expected 00000010 0", res_vec, ts_req);
        end
        n_tests++;
        rst_n = 1'b1;
        step("R1 after release");

        // R4: counters 0 and 2 in selector 2, sequencer state 1 in selector 3
        wr(6'd2, cw(0, 0, 4'd2, 16'h0005), "R4 write");
        wr(6'd3, cw(0, 0, 4'd2, 16'h2000), "R4 write");
        cnt_zero = 4'b0001; step("R4 cnt0");
        cnt_zero = 4'b0100; step("R4 cnt2");
        cnt_zero = 4'b1010; step("R4 cnt unselected");
        seq_state = 4'b0010; step("R4 seq1");
        cnt_zero = 4'b0000; seq_state = 4'b0000; step("R4 idle");

        // R5: external and comparator groups, unused group code
        wr(6'd4, cw(0, 0, 4'd0, 16'h00F0), "R5 write");
        wr(6'd5, cw(0, 0, 4'd1, 16'h8001), "R5 write");
        wr(6'd6, cw(0, 0, 4'd7, 16'hFFFF), "R5 write");
        ext_in = 16'h0010; step("R5 ext");
        ext_in = 16'h0F0F; cmp_in = 16'h8000; step("R5 cmp");
        ext_in = 16'hFFFF; cmp_in = 16'hFFFF; step("R5 bad group");
        wr(6'd6, cw(0, 1, 4'd9, 16'hFFFF), "R5 bad group inv");
        step("R5 bad group inv");

        // R6: inversion, pair-invert leaves single entries alone
        wr(6'd7, cw(0, 1, 4'd0, 16'h0001), "R6 write");
        ext_in = 16'h0000; step("R6 inv low");
        ext_in = 16'h0001; step("R6 inv high");
        wr(6'd2, cw(1, 0, 4'd2, 16'h0001), "R6 pinv only");
        cnt_zero = 4'b0000; step("R6 pinv not inverted");
        cnt_zero = 4'b0001; step("R6 pinv not inverted");

        // R2: fixed entries ignore writes
        wr(6'd0, cw(1, 1, 4'd0, 16'hFFFF), "R2 write 0");
        wr(6'd1, cw(1, 1, 4'd0, 16'h0000), "R2 write 1");
        step("R2 fixed");

        // R10: out of range addresses ignored
        wr(6'd10, cw(0, 1, 4'd0, 16'h0000), "R10 ignored");
        wr(6'd33, 22'h000001, "R10 ignored");
        step("R10 ignored");

        // R7 / R9: single event on selector 4
        wr(6'd32, 22'h000004, "R7 ts write");
        for (int k = 0; k < 6; k++) begin
            ext_in = (k % 2 == 0) ? 16'h0020 : 16'h0000;
            step("R9 pulse follows event");
        end
        wr(6'd32, 22'h000001, "R9 always true");
        repeat (3) step("R9 continuous");
        wr(6'd32, 22'h000014, "R7 out of range");
        repeat (2) step("R7 out of range");
        wr(6'd32, 22'h000067, "R7 ignored bits");
        repeat (2) step("R7 ignored bits");

        // R8: pair events
        wr(6'd2, cw(0, 0, 4'd2, 16'h0001), "R8 write");
        wr(6'd3, cw(1, 0, 4'd2, 16'h0002), "R8 odd pinv");
        wr(6'd32, 22'h000081, "R8 pair1");
        cnt_zero = 4'b0000; repeat (2) step("R8 pair1 low");
        cnt_zero = 4'b0010; repeat (2) step("R8 pair1 high");
        wr(6'd2, cw(1, 0, 4'd2, 16'h0001), "R8 pinv");
        repeat (2) step("R8 pair1 inverted");
        cnt_zero = 4'b0000; repeat (2) step("R8 pair1 inverted low");
        wr(6'd32, 22'h000080, "R8 pair0");
        repeat (2) step("R8 pair0 false");
        wr(6'd32, 22'h000085, "R8 pair out of range");
        repeat (2) step("R8 pair out of range");

        // R10 / R9: write in the same cycle as a status change or a true event
        wr(6'd32, 22'h000004, "R9 ts");
        ext_in = 16'h0000;
        wr_en = 1'b1; wr_addr = 6'd4; wr_data = cw(0, 0, 4'd0, 16'h0001);
        ext_in = 16'h0001;
        step("R10 same cycle");
        wr_en = 1'b0;
        repeat (2) step("R10 new control");
        wr(6'd32, 22'h000000, "R9 retarget while true");
        repeat (2) step("R9 retarget");

        // R3: random traffic
        for (int k = 0; k < 600; k++) begin
            wr_en     = ($urandom_range(0, 3) == 0);
            wr_addr   = ($urandom_range(0, 4) == 0) ? 6'd32 : 6'($urandom_range(0, 12));
            wr_data   = 22'($urandom);
            ext_in    = 16'($urandom);
            cmp_in    = 16'($urandom);
            cnt_zero  = 4'($urandom);
            seq_state = 4'($urandom);
            step("R3 random");
        end
        wr_en = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule